// File: doc/BRIEF.md
# Framed Six-Channel Serial Receiver

This block is the host-side capture logic for a converter that sends its samples as short serial bursts. A fast system clock oversamples the incoming serial clock, framing and data lines through two-flop synchronizers. A high pulse on the framing line, followed by its falling edge, arms a capture. The next 96 rising serial clock edges each shift in one data bit. At the end of a complete frame, six 16-bit words appear on one parallel bus, and a strobe marks the frame as valid for one system clock cycle.

A frame that is cut short by a new framing pulse is thrown away and reported. A serial clock edge that arrives while no frame is armed is also reported.

The block also drives the converter's active-low reset. This output stays low for a programmable number of cycles after system reset, which covers the supply settling time. A software request pulls it low for at least a minimum pulse width. That width is derived from the system clock period.

Top module: `frame6_rx`

## Requirements
- R1: While `rst_n` is low, `frame_valid`, `frame_err` and `proto_err` are 0, `frame_data` is all zeros and `conv_rst_n` is 0.
- R2: After `rst_n` is released, `conv_rst_n` stays low for PWRUP_CYC system clock cycles and then goes high.
- R3: A cycle with `sw_rst_req` high drives `conv_rst_n` low from the next clock edge. It stays low for at least RST_CYC cycles, where RST_CYC = ceil(MIN_PULSE_PS / CLK_PERIOD_PS), which is 10 with the default values.
- R4: A capture is armed only by the falling edge of `ser_frm`. After that, the bit on `ser_dat` is taken at each synchronized rising edge of `ser_clk`, until exactly 96 bits have been taken.
- R5: The bits arrive most significant first. In `frame_data`, the first bit received lands in bit 95 and the last in bit 0. The word fields are: V1 in [95:80], I1 in [79:64], V2 in [63:48], I2 in [47:32], V3 in [31:16] and I3 in [15:0].
- R6: `frame_valid` goes high for exactly one cycle per completed frame, in the same cycle that `frame_data` takes the new frame.
- R7: `frame_data` changes only when a frame completes, and otherwise holds its value.
- R8: If `ser_frm` rises while a capture is armed, the partial frame is discarded and `frame_err` pulses for one cycle. `frame_data` is left unchanged, and the following frame is captured normally.
- R9: A rising `ser_clk` edge seen while no capture is armed shifts in nothing, leaves `frame_data` unchanged and pulses `proto_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset (power-up) |
| sw_rst_req | input | 1 | Software request for a converter reset pulse |
| ser_clk | input | 1 | Serial clock from the converter |
| ser_frm | input | 1 | Framing pulse from the converter |
| ser_dat | input | 1 | Serial data from the converter |
| conv_rst_n | output | 1 | Active-low reset to the converter |
| frame_data | output | 96 | Six received words, V1 in the top field |
| frame_valid | output | 1 | One-cycle strobe when a frame completes |
| frame_err | output | 1 | One-cycle pulse when a frame is cut short |
| proto_err | output | 1 | One-cycle pulse on a serial clock edge outside a frame |

## Verification
The bench sends frames with distinct word patterns. A receiver that reversed the bit order, swapped the word fields or slipped a bit would put wrong words into the scoreboard compare.

It also cuts a frame short after 40 bits and then sends a full frame. A design that kept the stale partial bits would corrupt that next frame, and one that published the partial frame would change `frame_data` without a valid frame.

Stray serial clock edges between frames are sent to check that they are not shifted in as data and that each one is reported. The lengths of the reset output's power-up hold and software pulse are counted in system clock cycles, which exposes an off-by-one count or a pulse that is too short.

// File: rtl/frame6_rx.sv
module frame6_rx #(
  parameter int WORD_W        = 16,
  parameter int NUM_WORDS     = 6,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int MIN_PULSE_PS  = 50000,
  parameter int PWRUP_CYC     = 200
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sw_rst_req,
  input  logic                          ser_clk,
  input  logic                          ser_frm,
  input  logic                          ser_dat,
  output logic                          conv_rst_n,
  output logic [WORD_W*NUM_WORDS-1:0]   frame_data,
  output logic                          frame_valid,
  output logic                          frame_err,
  output logic                          proto_err
);
  localparam int FRAME_W = WORD_W * NUM_WORDS;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int RST_RAW = (MIN_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam int RC_MAX  = (PWRUP_CYC > RST_CYC) ? PWRUP_CYC : RST_CYC;
  localparam int RC_W    = $clog2(RC_MAX + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [2:0] sclk_sr, frm_sr;
  logic [1:0] dat_sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sr <= '0;
      frm_sr  <= '0;
      dat_sr  <= '0;
    end else begin
      sclk_sr <= {sclk_sr[1:0], ser_clk};
      frm_sr  <= {frm_sr[1:0], ser_frm};
      dat_sr  <= {dat_sr[0], ser_dat};
    end

  wire sclk_rise = sclk_sr[1] & ~sclk_sr[2];
  wire frm_rise  = frm_sr[1] & ~frm_sr[2];
  wire frm_fall  = ~frm_sr[1] & frm_sr[2];
  wire dat_s     = dat_sr[1];

  logic               armed;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed       <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      frame_data  <= '0;
      frame_valid <= 1'b0;
      frame_err   <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      frame_err   <= 1'b0;
      proto_err   <= 1'b0;
      if (frm_rise) begin
        if (armed) frame_err <= 1'b1;
        armed <= 1'b0;
      end else if (frm_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        if (!armed) begin
          proto_err <= 1'b1;
        end else begin
          shreg <= {shreg[FRAME_W-3:0], dat_s};
          if (bit_cnt == LAST) begin
            armed       <= 1'b0;
            frame_data  <= {shreg, dat_s};
            frame_valid <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
      end
    end

  logic [RC_W-1:0] rst_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      rst_cnt <= RC_W'(PWRUP_CYC);
    else if (sw_rst_req && rst_cnt < RC_W'(RST_CYC))
      rst_cnt <= RC_W'(RST_CYC);
    else if (rst_cnt != '0)
      rst_cnt <= rst_cnt - RC_W'(1);

  assign conv_rst_n = (rst_cnt == '0);

  AST_SW_RST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req |=> !conv_rst_n); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_data)); // R7
  AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !frame_valid && $stable(frame_data)); // R8
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $stable(frame_data)); // R9
endmodule

// File: tb/frame6_rx_bench.sv
`timescale 1ns/1ps
module frame6_rx_bench;
  localparam int PWRUP = 200;
  localparam int RSTC  = (50000 + 5000 - 1) / 5000;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0, sw_rst_req = 0, ser_clk = 0, ser_frm = 0, ser_dat = 0;
  logic conv_rst_n, frame_valid, frame_err, proto_err;
  logic [95:0] frame_data;

  frame6_rx u_frame6_rx (.clk(clk), .rst_n(rst_n), .sw_rst_req(sw_rst_req),
    .ser_clk(ser_clk), .ser_frm(ser_frm), .ser_dat(ser_dat), .conv_rst_n(conv_rst_n),
    .frame_data(frame_data), .frame_valid(frame_valid), .frame_err(frame_err),
    .proto_err(proto_err));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int n_valid = 0, n_ferr = 0, n_perr = 0;
  logic [95:0] exp_q[$];
  logic [95:0] last_data = '0;
  logic prev_valid = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (frame_valid) begin
      n_valid++;
      if (exp_q.size() == 0) chk(0, "R4 unexpected frame", frame_data, '0);
      else begin
        logic [95:0] e;
        e = exp_q.pop_front();
        chk(frame_data == e, "R5 frame words", frame_data, e);
      end
      last_data = frame_data;
    end else if (frame_data != last_data) begin
      chk(0, "R7 data changed without valid", frame_data, last_data);
    end
    if (frame_valid && prev_valid) chk(0, "R6 strobe longer than one cycle", 96'd2, 96'd1);
    prev_valid = frame_valid;
    if (frame_err) n_ferr++;
    if (proto_err) n_perr++;
  end

  function automatic logic [95:0] pack(input logic [15:0] v1, i1, v2, i2, v3, i3);
    return {v1, i1, v2, i2, v3, i3};
  endfunction

  task automatic send_bits(input logic [95:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = v[95-i];
      repeat (HALF) @(negedge clk);
      ser_clk = 1;
      repeat (HALF) @(negedge clk);
      ser_clk = 0;
    end
  endtask

  task automatic frame_pulse();
    ser_frm = 1;
    repeat (2*HALF) @(negedge clk);
    ser_frm = 0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic send_frame(input logic [95:0] v);
    exp_q.push_back(v);
    frame_pulse();
    send_bits(v, 96);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int cnt;
    logic [95:0] keep;
    repeat (3) @(negedge clk);
    chk(conv_rst_n == 0 && frame_valid == 0 && frame_err == 0 && proto_err == 0,
        "R1 reset outputs", {92'd0, conv_rst_n, frame_valid, frame_err, proto_err}, '0);
    chk(frame_data == '0, "R1 reset data", frame_data, '0);
    rst_n = 1;
    cnt = 0;
    while (!conv_rst_n && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == PWRUP, "R2 power-up hold cycles", 96'(cnt), 96'(PWRUP));

    send_frame(pack(16'h8001, 16'h1234, 16'h5678, 16'h9abc, 16'hdef0, 16'h0ff1));
    send_frame('1);
    send_frame({48{2'b10}});
    send_frame(pack(16'h0001, 16'h0002, 16'h0004, 16'h0008, 16'h0010, 16'h8000));
    chk(n_valid == 4, "R6 one strobe per frame", 96'(n_valid), 96'd4);

    keep = frame_data;
    frame_pulse();
    send_bits({96{1'b1}} ^ 96'h5, 40);
    frame_pulse();
    repeat (6) @(negedge clk);
    chk(n_ferr == 1, "R8 abort flagged", 96'(n_ferr), 96'd1);
    chk(frame_data == keep, "R8 partial frame discarded", frame_data, keep);
    send_bits(96'h0, 0);
    begin
      logic [95:0] v = pack(16'hcafe, 16'hbeef, 16'h0bad, 16'hf00d, 16'h1357, 16'h2468);
      exp_q.push_back(v);
      send_bits(v, 96);
      repeat (8) @(negedge clk);
    end
    chk(n_valid == 5, "R8 frame after abort captured", 96'(n_valid), 96'd5);

    keep = frame_data;
    ser_dat = 1;
    send_bits('0, 3);
    repeat (8) @(negedge clk);
    chk(n_perr == 3, "R9 stray edges flagged", 96'(n_perr), 96'd3);
    chk(frame_data == keep && n_valid == 5, "R9 stray edges ignored", frame_data, keep);

    sw_rst_req = 1;
    @(negedge clk);
    sw_rst_req = 0;
    cnt = 0;
    while (!conv_rst_n && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt >= RSTC, "R3 software reset width", 96'(cnt), 96'(RSTC));

    send_frame(pack(16'h7fff, 16'h8000, 16'h0000, 16'hffff, 16'haaaa, 16'h5555));
    chk(exp_q.size() == 0, "R4 all frames received", 96'(exp_q.size()), '0);
    chk(n_ferr == 1 && n_perr == 3, "R9 no extra error pulses", 96'(n_ferr + n_perr), 96'd4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule